// File: doc/BRIEF.md
# Decimal Adjust-After-Addition Unit

This block applies the decimal correction that follows a binary addition of decimal digits held in an 8-bit accumulator. Given the raw sum in the accumulator, the high byte that goes with it, and the auxiliary-carry and carry flags the addition produced, it returns the corrected accumulator, high byte and flags. The addition itself happens elsewhere.

Two correction styles are offered. The first is for one digit per byte, as in ASCII digit arithmetic. Its result is a single digit in the low nibble, and any decimal carry is pushed into the high byte. The second is for two digits per byte, in packed BCD. It adds 0x06 and/or 0x60 to the accumulator so that both nibbles become valid digits again, and it leaves the high byte alone.

The caller presents operands with a one-cycle start strobe. The result is registered and is flagged by a done pulse on the following cycle. The outputs then keep their value until the next strobe.

Top module: `decadj_unit`

## Requirements
- R1: While rst_n is low, and right after it rises, acc_o, hi_o, aux_o, carry_o and done_o are all 0.
- R2: done_o is 1 in the cycle after each cycle in which start_i is 1, and 0 in the cycle after a cycle in which start_i is 0.
- R3: In a cycle with start_i at 0, no input has any effect: acc_o, hi_o, aux_o and carry_o keep their previous values.
- R4: With mode_i = 0 (one digit per byte), if acc_i[3:0] > 9 or aux_i = 1, the result is acc_o = (acc_i + 6) mod 256 AND 0x0F, with aux_o = 1 and carry_o = 1.
- R5: With mode_i = 0 and the condition of R4 true, hi_o = hi_i + 1, plus one more when acc_i > 0xF9, modulo 256.
- R6: With mode_i = 0 and the condition of R4 false, acc_o = acc_i AND 0x0F, hi_o = hi_i, aux_o = 0 and carry_o = 0, whatever carry_i is.
- R7: With mode_i = 1 (packed), if acc_i[3:0] > 9 or aux_i = 1, then 0x06 is added to the accumulator and aux_o = 1; otherwise aux_o = 0.
- R8: With mode_i = 1, if (acc_i AND 0xF0) > 0x90 or carry_i = 1, then 0x60 is added to the accumulator and carry_o = 1; otherwise carry_o = 0. All sums are taken mod 256.
- R9: With mode_i = 1, both conditions are judged on the incoming acc_i, before any correction is applied, and hi_o = hi_i. If neither condition holds, acc_o = acc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; operands are sampled when this is 1 |
| mode_i | input | 1 | 0 = one digit per byte, 1 = packed two digits per byte |
| acc_i | input | 8 | Accumulator value after the binary add |
| hi_i | input | 8 | High byte that goes with the accumulator |
| aux_i | input | 1 | Auxiliary (nibble) carry flag from the add |
| carry_i | input | 1 | Carry flag from the add |
| acc_o | output | 8 | Corrected accumulator |
| hi_o | output | 8 | Updated high byte |
| aux_o | output | 1 | Updated auxiliary carry flag |
| carry_o | output | 1 | Updated carry flag |
| done_o | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The assertions assume that mode_i, acc_i, hi_i, aux_i and carry_i carry known values at every clock edge where start_i is 1. They make no such assumption for the other edges, because those inputs are ignored there. The bench only changes inputs on the falling edge, so every operand is stable across the rising edge that samples it. Between strobes the bench leaves the start strobe low and deliberately changes the operand and mode inputs, so the checks on held outputs exercise real activity on the ignored inputs.

// File: rtl/decadj_pkg.sv
package decadj_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = BYTE_W / 2;
    localparam int DEC_MAX = 9;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        ADJ_DIGIT  = 1'b0,
        ADJ_PACKED = 1'b1
    } adj_mode_e;

    typedef struct packed {
        byte_t acc;
        byte_t hi;
        logic  aux;
        logic  carry;
        logic  done;
    } adj_state_t;

endpackage

// File: rtl/decadj_digit_check.sv
module decadj_digit_check
    import decadj_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [W-1:0] digit_i,
    input  logic         force_i,
    output logic         fix_o
);
    localparam logic [W-1:0] LIMIT = W'(DEC_MAX);

    always_comb begin
        fix_o = (digit_i > LIMIT) | force_i;
    end
endmodule

// File: rtl/decadj_digit_mode.sv
module decadj_digit_mode
    import decadj_pkg::*;
(
    input  byte_t acc_i,
    input  byte_t hi_i,
    input  logic  aux_i,
    output byte_t acc_o,
    output byte_t hi_o,
    output logic  flag_o
);
    localparam byte_t SIX      = BYTE_W'(6);
    localparam byte_t WRAP_MAX = BYTE_W'(2**BYTE_W - 1 - 6);
    localparam byte_t LO_MASK  = BYTE_W'(2**NIB_W - 1);

    logic  fix;
    logic  spill;
    byte_t bump;

    decadj_digit_check #(.W(NIB_W)) u_lo (
        .digit_i (acc_i[NIB_W-1:0]),
        .force_i (aux_i),
        .fix_o   (fix)
    );

    always_comb begin
        spill = (acc_i > WRAP_MAX);
        bump  = spill ? BYTE_W'(2) : BYTE_W'(1);
        if (fix) begin
            acc_o  = (acc_i + SIX) & LO_MASK;
            hi_o   = hi_i + bump;
            flag_o = 1'b1;
        end else begin
            acc_o  = acc_i & LO_MASK;
            hi_o   = hi_i;
            flag_o = 1'b0;
        end
    end
endmodule

// File: rtl/decadj_packed_mode.sv
module decadj_packed_mode
    import decadj_pkg::*;
(
    input  byte_t acc_i,
    input  logic  aux_i,
    input  logic  carry_i,
    output byte_t acc_o,
    output logic  aux_o,
    output logic  carry_o
);
    localparam byte_t LO_STEP = BYTE_W'(6);
    localparam byte_t HI_STEP = BYTE_W'(6 << NIB_W);

    logic lo_fix;
    logic hi_fix;

    decadj_digit_check #(.W(NIB_W)) u_lo (
        .digit_i (acc_i[NIB_W-1:0]),
        .force_i (aux_i),
        .fix_o   (lo_fix)
    );

    decadj_digit_check #(.W(NIB_W)) u_hi (
        .digit_i (acc_i[BYTE_W-1:NIB_W]),
        .force_i (carry_i),
        .fix_o   (hi_fix)
    );

    always_comb begin
        acc_o   = acc_i + (lo_fix ? LO_STEP : '0) + (hi_fix ? HI_STEP : '0);
        aux_o   = lo_fix;
        carry_o = hi_fix;
    end
endmodule

// File: rtl/decadj_unit.sv
module decadj_unit
    import decadj_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] hi_i,
    input  logic       aux_i,
    input  logic       carry_i,
    output logic [7:0] acc_o,
    output logic [7:0] hi_o,
    output logic       aux_o,
    output logic       carry_o,
    output logic       done_o
);
    adj_state_t st_d, st_q;

    byte_t dg_acc, dg_hi;
    logic  dg_flag;
    byte_t pk_acc;
    logic  pk_aux, pk_carry;

    decadj_digit_mode u_digit (
        .acc_i  (acc_i),
        .hi_i   (hi_i),
        .aux_i  (aux_i),
        .acc_o  (dg_acc),
        .hi_o   (dg_hi),
        .flag_o (dg_flag)
    );

    decadj_packed_mode u_packed (
        .acc_i   (acc_i),
        .aux_i   (aux_i),
        .carry_i (carry_i),
        .acc_o   (pk_acc),
        .aux_o   (pk_aux),
        .carry_o (pk_carry)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            st_d.done = 1'b1;
            if (adj_mode_e'(mode_i) == ADJ_PACKED) begin
                st_d.acc   = pk_acc;
                st_d.hi    = hi_i;
                st_d.aux   = pk_aux;
                st_d.carry = pk_carry;
            end else begin
                st_d.acc   = dg_acc;
                st_d.hi    = dg_hi;
                st_d.aux   = dg_flag;
                st_d.carry = dg_flag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o   = st_q.acc;
    assign hi_o    = st_q.hi;
    assign aux_o   = st_q.aux;
    assign carry_o = st_q.carry;
    assign done_o  = st_q.done;
endmodule

// File: rtl/decadj_unit_chk.sv
module decadj_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       mode_i,
    input logic [7:0] acc_i,
    input logic [7:0] hi_i,
    input logic       aux_i,
    input logic       carry_i,
    input logic [7:0] acc_o,
    input logic [7:0] hi_o,
    input logic       aux_o,
    input logic       carry_o,
    input logic       done_o
);
    a_r2_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    a_r2_no_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);

    a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(acc_o) && $stable(hi_o) && $stable(aux_o) && $stable(carry_o)));

    a_r4_digit_fix_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_i && ((acc_i[3:0] > 4'd9) || aux_i)) |=> (aux_o && carry_o));

    a_r6_digit_high_nibble_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !mode_i) |=> (acc_o[7:4] == 4'd0 && aux_o == carry_o));

    a_r8_packed_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i && carry_i) |=> carry_o);

    a_r9_packed_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mode_i) |=> (hi_o == $past(hi_i)));
endmodule

bind decadj_unit decadj_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .acc_i   (acc_i),
    .hi_i    (hi_i),
    .aux_i   (aux_i),
    .carry_i (carry_i),
    .acc_o   (acc_o),
    .hi_o    (hi_o),
    .aux_o   (aux_o),
    .carry_o (carry_o),
    .done_o  (done_o)
);

// File: tb/decadj_unit_tb.sv
module decadj_unit_tb;

    typedef struct packed {
        logic       mode;
        logic [7:0] acc;
        logic [7:0] hi;
        logic       aux;
        logic       carry;
        logic [7:0] e_acc;
        logic [7:0] e_hi;
        logic       e_aux;
        logic       e_carry;
        logic [7:0] req;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        // one digit per byte
        '{1'b0, 8'h66, 8'h00, 1'b0, 1'b0, 8'h06, 8'h00, 1'b0, 1'b0, 8'd6}, // R6 sum example
        '{1'b0, 8'h6B, 8'h01, 1'b0, 1'b0, 8'h01, 8'h02, 1'b1, 1'b1, 8'd4}, // R4 digit > 9
        '{1'b0, 8'h03, 8'h05, 1'b1, 1'b0, 8'h09, 8'h06, 1'b1, 1'b1, 8'd4}, // R4 forced by aux
        '{1'b0, 8'hFA, 8'h10, 1'b0, 1'b0, 8'h00, 8'h12, 1'b1, 1'b1, 8'd5}, // R5 extra increment
        '{1'b0, 8'hF9, 8'h10, 1'b1, 1'b0, 8'h0F, 8'h11, 1'b1, 1'b1, 8'd5}, // R5 boundary F9
        '{1'b0, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h05, 8'h01, 1'b1, 1'b1, 8'd5}, // R5 high byte wraps
        '{1'b0, 8'h39, 8'h00, 1'b0, 1'b1, 8'h09, 8'h00, 1'b0, 1'b0, 8'd6}, // R6 carry_i ignored
        // packed
        '{1'b1, 8'h15, 8'hAA, 1'b0, 1'b0, 8'h15, 8'hAA, 1'b0, 1'b0, 8'd9}, // R9 no fix
        '{1'b1, 8'h1C, 8'h33, 1'b0, 1'b0, 8'h22, 8'h33, 1'b1, 1'b0, 8'd7}, // R7 low digit
        '{1'b1, 8'h13, 8'h00, 1'b1, 1'b0, 8'h19, 8'h00, 1'b1, 1'b0, 8'd7}, // R7 forced by aux
        '{1'b1, 8'hA2, 8'h44, 1'b0, 1'b0, 8'h02, 8'h44, 1'b0, 1'b1, 8'd8}, // R8 high digit
        '{1'b1, 8'h92, 8'h00, 1'b0, 1'b0, 8'h92, 8'h00, 1'b0, 1'b0, 8'd8}, // R8 boundary 0x90
        '{1'b1, 8'h22, 8'h00, 1'b0, 1'b1, 8'h82, 8'h00, 1'b0, 1'b1, 8'd8}, // R8 forced by carry
        '{1'b1, 8'h9A, 8'h07, 1'b0, 1'b0, 8'hA0, 8'h07, 1'b1, 1'b0, 8'd9}, // R9 judged on input
        '{1'b1, 8'hAB, 8'h00, 1'b0, 1'b0, 8'h11, 8'h00, 1'b1, 1'b1, 8'd8}, // R8 both fixes
        '{1'b1, 8'hFF, 8'h5A, 1'b1, 1'b1, 8'h65, 8'h5A, 1'b1, 1'b1, 8'd7}  // R7 both forced
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] acc_i = '0;
    logic [7:0] hi_i = '0;
    logic       aux_i = 1'b0;
    logic       carry_i = 1'b0;
    logic [7:0] acc_o, hi_o;
    logic       aux_o, carry_o, done_o;

    int n_run = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    decadj_unit u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mode_i  (mode_i),
        .acc_i   (acc_i),
        .hi_i    (hi_i),
        .aux_i   (aux_i),
        .carry_i (carry_i),
        .acc_o   (acc_o),
        .hi_o    (hi_o),
        .aux_o   (aux_o),
        .carry_o (carry_o),
        .done_o  (done_o)
    );

    task automatic check(input string tag, input logic [19:0] got, input logic [19:0] exp);
        n_run++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [19:0] outs();
        return {acc_o, hi_o, aux_o, carry_o, done_o, 1'b0};
    endfunction

    task automatic issue(input logic m, input logic [7:0] a, input logic [7:0] h,
                         input logic f, input logic c);
        @(negedge clk);
        mode_i = m; acc_i = a; hi_i = h; aux_i = f; carry_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        logic [19:0] held;
        // R1 reset values
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), 20'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), 20'h0);

        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].mode, VECS[i].acc, VECS[i].hi, VECS[i].aux, VECS[i].carry);
            n_run++;
            if ({acc_o, hi_o, aux_o, carry_o, done_o} !==
                {VECS[i].e_acc, VECS[i].e_hi, VECS[i].e_aux, VECS[i].e_carry, 1'b1}) begin
                n_bad++;
                $display("FAIL R%0d vec %0d: got %h %h %b %b %b expected %h %h %b %b 1",
                         VECS[i].req, i, acc_o, hi_o, aux_o, carry_o, done_o,
                         VECS[i].e_acc, VECS[i].e_hi, VECS[i].e_aux, VECS[i].e_carry);
            end
        end

        // R2 done falls the cycle after
        @(negedge clk);
        check("R2 done single pulse", {19'h0, done_o}, 20'h0);

        // R3 ignored inputs without start
        held = outs();
        mode_i = 1'b0; acc_i = 8'h7F; hi_i = 8'h01; aux_i = 1'b1; carry_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 hold after input change", outs(), held);

        // R2 back-to-back strobes, second result replaces first
        @(negedge clk);
        mode_i = 1'b1; acc_i = 8'h05; hi_i = 8'h00; aux_i = 1'b0; carry_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        check("R2 first of pair", outs(), {8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0});
        mode_i = 1'b0; acc_i = 8'h2C; hi_i = 8'h09;
        @(negedge clk);
        start_i = 1'b0;
        check("R4 R5 second of pair", outs(), {8'h02, 8'h0A, 1'b1, 1'b1, 1'b1, 1'b0});
        @(negedge clk);
        check("R2 pair ends", outs(), {8'h02, 8'h0A, 1'b1, 1'b1, 1'b0, 1'b0});

        // R1 reset mid-run clears result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears result", outs(), 20'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule